// File: doc/BRIEF.md
# Synchronous Buck Gate-Drive Sequencer

This block converts a single PWM request into two complementary gate enables for a synchronous buck power stage: one for the high-side switch and one for the low-side switch. It runs the break-before-make handshake for both edges of the switching period. When the high side releases, the low side waits until a comparator reports that the switch node has dropped near ground. When the low side releases, a fixed dead interval passes before the high side can turn on again.

The sequencer also keeps the bootstrap capacitor charged. A minimum off interval, with the low side on, is inserted only when the bootstrap comparator reports a low voltage. When that voltage is healthy, the PWM request may stay high for almost the whole period. A light-load request keeps the low side off so the stage behaves like a diode rectifier. The bootstrap refresh pulse is the only case that still drives the low side during light load.

All timing is counted in clock cycles. The cycle counts are derived from a clock-period parameter and from intervals given in picoseconds. A shutdown input clears both enables in the same cycle.

Top module: `buck_gate_seq`

## Requirements
- R1: While idle with the bootstrap healthy, a high PWM request sampled at a clock edge turns the high-side enable on and keeps the low-side enable off from that edge onward. The high side then remains on as long as the request stays high and the bootstrap stays healthy.
- R2: After the high side turns off with the bootstrap healthy and light load inactive, both enables stay low until the switch-node-low input is sampled high. The low side turns on at that edge.
- R3: After the low side turns off, both enables stay low for DEAD_CYC cycles before the high side turns on. DEAD_CYC is the dead time divided by the clock period, rounded up, and equals 7 at the default values.
- R4: If the switch-node-low input never rises after the high side turns off, the low side turns on after SW_TIMEOUT_CYC cycles with both enables low. The default is 12 cycles.
- R5: A low bootstrap input ends a high-side phase. After the switch-node wait, the low side is then forced on for MIN_OFF_CYC cycles (default 25), even if the bootstrap recovers meanwhile. A dead interval follows before the high side returns. A PWM rise while idle with the bootstrap low also starts this refresh.
- R6: With the light-load input high, the low side is not turned on after a high-side phase. If light load rises while the low side is on, the low side turns off and a dead interval starts. A bootstrap refresh still drives the low side for its full length.
- R7: A high shutdown input forces both enables low within the same cycle and returns the sequencer to idle, abandoning any refresh. Once shutdown is released, the first edge with the PWM request high turns the high side on.
- R8: The high-side and low-side enables are never high in the same cycle.
- R9: With the bootstrap healthy, no minimum off interval is forced. If the PWM request returns high before the low side has turned on, the high side turns back on at the next edge without a dead interval.
- R10: During reset both enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pwm_i | input | 1 | PWM request; high asks for the high side |
| sw_low_i | input | 1 | Switch node below its low threshold (comparator output) |
| bst_ok_i | input | 1 | Bootstrap voltage above its refresh threshold (comparator output) |
| lowcur_i | input | 1 | Light-load request: keep the low side off |
| shdn_i | input | 1 | Shutdown; forces both enables low |
| hs_en_o | output | 1 | High-side gate enable |
| ls_en_o | output | 1 | Low-side gate enable |

## Verification
Two functions can fall in the same cycle. The bootstrap refresh and the light-load hold-off meet when the bootstrap input falls at the end of a high phase while light load is active. The bench expects the low side to be forced on for the full refresh length anyway. After the refresh it expects a dead interval and then idle, with no return to the low side. Shutdown is also raised in the middle of a refresh, and the bench expects the forced low-side pulse to end at once and not resume after release.

// File: rtl/gate_seq_pkg.sv
`timescale 1ns/1ps
package gate_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_HIGH    = 3'd1,
    ST_SW_WAIT = 3'd2,
    ST_LOW     = 3'd3,
    ST_DEAD    = 3'd4,
    ST_REFRESH = 3'd5
  } seq_state_e;

  function automatic int cyc_ceil(input int span_ps, input int period_ps);
    int c;
    c = (span_ps + period_ps - 1) / period_ps;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/gate_seq_timer.sv
`timescale 1ns/1ps
module gate_seq_timer #(
  parameter int CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          done_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/gate_seq_fsm.sv
`timescale 1ns/1ps
module gate_seq_fsm
  import gate_seq_pkg::*;
#(
  parameter int DEAD_CYC       = 7,
  parameter int MIN_OFF_CYC    = 25,
  parameter int SW_TIMEOUT_CYC = 12,
  parameter int CW             = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwm_i,
  input  logic sw_low_i,
  input  logic bst_ok_i,
  input  logic lowcur_i,
  input  logic shdn_i,
  output logic hs_req_o,
  output logic ls_req_o
);

  localparam logic [CW-1:0] DEAD_LD = CW'(DEAD_CYC - 1);
  localparam logic [CW-1:0] MOFF_LD = CW'(MIN_OFF_CYC - 1);
  localparam logic [CW-1:0] SWTO_LD = CW'(SW_TIMEOUT_CYC - 1);

  seq_state_e    st_q, st_d;
  logic          tmr_done, tmr_load;
  logic [CW-1:0] tmr_val;

  always_comb begin
    st_d = st_q;
    if (shdn_i) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: if (pwm_i) st_d = bst_ok_i ? ST_HIGH : ST_REFRESH;
        ST_HIGH: if (!pwm_i || !bst_ok_i) st_d = ST_SW_WAIT;
        ST_SW_WAIT: begin
          if (pwm_i && bst_ok_i)          st_d = ST_HIGH;  // low side never on: no dead time
          else if (sw_low_i || tmr_done) begin
            if (!bst_ok_i)                st_d = ST_REFRESH;
            else if (lowcur_i)            st_d = ST_IDLE;
            else                          st_d = ST_LOW;
          end
        end
        ST_LOW: if (pwm_i || lowcur_i) st_d = ST_DEAD;
        ST_DEAD: if (tmr_done) begin
          if (pwm_i) st_d = bst_ok_i ? ST_HIGH : ST_REFRESH;
          else       st_d = ST_IDLE;
        end
        ST_REFRESH: if (tmr_done) st_d = (!pwm_i && !lowcur_i) ? ST_LOW : ST_DEAD;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  // one counter serves every timed state; reload on each state change
  always_comb begin
    tmr_load = (st_d != st_q);
    unique case (st_d)
      ST_DEAD:    tmr_val = DEAD_LD;
      ST_REFRESH: tmr_val = MOFF_LD;
      ST_SW_WAIT: tmr_val = SWTO_LD;
      default:    tmr_val = '0;
    endcase
  end

  gate_seq_timer #(.CW(CW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .done_o     (tmr_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign hs_req_o = (st_q == ST_HIGH);
  assign ls_req_o = (st_q == ST_LOW) || (st_q == ST_REFRESH);

endmodule

// File: rtl/gate_interlock.sv
`timescale 1ns/1ps
module gate_interlock (
  input  logic hs_req_i,
  input  logic ls_req_i,
  input  logic shdn_i,
  output logic hs_en_o,
  output logic ls_en_o
);

  // conflicting requests drop both gates
  assign hs_en_o = hs_req_i & ~ls_req_i & ~shdn_i;
  assign ls_en_o = ls_req_i & ~hs_req_i & ~shdn_i;

endmodule

// File: rtl/buck_gate_seq.sv
`timescale 1ns/1ps
module buck_gate_seq
  import gate_seq_pkg::*;
#(
  parameter int CLK_PERIOD_PS  = 8000,
  parameter int DEAD_TIME_PS   = 50000,
  parameter int MIN_OFF_PS     = 200000,
  parameter int SW_TIMEOUT_CYC = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwm_i,
  input  logic sw_low_i,
  input  logic bst_ok_i,
  input  logic lowcur_i,
  input  logic shdn_i,
  output logic hs_en_o,
  output logic ls_en_o
);

  localparam int DEAD_CYC    = cyc_ceil(DEAD_TIME_PS, CLK_PERIOD_PS);
  localparam int MIN_OFF_CYC = cyc_ceil(MIN_OFF_PS, CLK_PERIOD_PS);
  localparam int SW_TO_CYC   = (SW_TIMEOUT_CYC < 1) ? 1 : SW_TIMEOUT_CYC;
  localparam int MAX_A       = (DEAD_CYC > MIN_OFF_CYC) ? DEAD_CYC : MIN_OFF_CYC;
  localparam int MAX_CYC     = (MAX_A > SW_TO_CYC) ? MAX_A : SW_TO_CYC;
  localparam int CW          = $clog2(MAX_CYC + 1);

  logic hs_req, ls_req;

  gate_seq_fsm #(
    .DEAD_CYC       (DEAD_CYC),
    .MIN_OFF_CYC    (MIN_OFF_CYC),
    .SW_TIMEOUT_CYC (SW_TO_CYC),
    .CW             (CW)
  ) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pwm_i    (pwm_i),
    .sw_low_i (sw_low_i),
    .bst_ok_i (bst_ok_i),
    .lowcur_i (lowcur_i),
    .shdn_i   (shdn_i),
    .hs_req_o (hs_req),
    .ls_req_o (ls_req)
  );

  gate_interlock u_ilk (
    .hs_req_i (hs_req),
    .ls_req_i (ls_req),
    .shdn_i   (shdn_i),
    .hs_en_o  (hs_en_o),
    .ls_en_o  (ls_en_o)
  );

endmodule

// File: rtl/gate_seq_checker.sv
`timescale 1ns/1ps
module gate_seq_checker #(
  parameter int DEAD_CYC = 7
) (
  input logic clk_i,
  input logic rst_ni,
  input logic pwm_i,
  input logic bst_ok_i,
  input logic lowcur_i,
  input logic shdn_i,
  input logic hs_en_o,
  input logic ls_en_o
);

  localparam int GW = $clog2(DEAD_CYC + 1) + 1;

  logic [GW-1:0] ls_off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       ls_off_q <= GW'(DEAD_CYC);
    else if (ls_en_o)                  ls_off_q <= '0;
    else if (ls_off_q < GW'(DEAD_CYC)) ls_off_q <= ls_off_q + 1'b1;
  end

  a_r1_hs_needs_pwm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_en_o |-> $past(pwm_i));

  a_r3_dead_time: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_en_o) |-> (ls_off_q >= GW'(DEAD_CYC)));

  a_r6_lowcur_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ls_en_o) && $past(lowcur_i)) |-> $past(!bst_ok_i));

  a_r7_shdn_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shdn_i |-> (!hs_en_o && !ls_en_o));

  a_r8_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_en_o && ls_en_o));

endmodule

bind buck_gate_seq gate_seq_checker #(.DEAD_CYC(DEAD_CYC)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .pwm_i    (pwm_i),
  .bst_ok_i (bst_ok_i),
  .lowcur_i (lowcur_i),
  .shdn_i   (shdn_i),
  .hs_en_o  (hs_en_o),
  .ls_en_o  (ls_en_o)
);

// File: tb/buck_gate_seq_test.sv
`timescale 1ns/1ps
module buck_gate_seq_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwm = 1'b0, sw_low = 1'b0, bst_ok = 1'b1, lowcur = 1'b0, shdn = 1'b0;
  logic hs_en, ls_en;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  typedef struct {
    logic  hs;
    logic  ls;
    string tag;
  } exp_t;

  exp_t exp_q[$];

  always #4 clk = ~clk;

  buck_gate_seq uut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .pwm_i    (pwm),
    .sw_low_i (sw_low),
    .bst_ok_i (bst_ok),
    .lowcur_i (lowcur),
    .shdn_i   (shdn),
    .hs_en_o  (hs_en),
    .ls_en_o  (ls_en)
  );

  task automatic check(input string tag, input logic ah, input logic al,
                       input logic eh, input logic el);
    n_tests++;
    if (ah !== eh || al !== el) begin
      n_fail++;
      $display("FAIL %s: hs=%0b ls=%0b expected hs=%0b ls=%0b", tag, ah, al, eh, el);
    end
  endtask

  // drive one cycle of inputs and queue the outputs expected after the next edge
  task automatic step(input logic p, input logic s, input logic b, input logic l,
                      input logic d, input logic eh, input logic el, input string tag);
    exp_t e;
    @(negedge clk);
    pwm = p; sw_low = s; bst_ok = b; lowcur = l; shdn = d;
    e.hs = eh; e.ls = el; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic hold(input int n, input logic p, input logic s, input logic b,
                      input logic l, input logic d, input logic eh, input logic el,
                      input string tag);
    for (int i = 0; i < n; i++) step(p, s, b, l, d, eh, el, tag);
  endtask

  // monitor
  always @(posedge clk) begin
    #2;
    if (exp_q.size() != 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(e.tag, hs_en, ls_en, e.hs, e.ls);
      n_tests++;
      if (hs_en && ls_en) begin
        n_fail++;
        $display("FAIL R8: hs=1 ls=1 expected not both high");
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run not finished, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10", hs_en, ls_en, 1'b0, 1'b0);
    pwm = 1'b1;                       // request ignored while in reset
    @(negedge clk);
    check("R10", hs_en, ls_en, 1'b0, 1'b0);
    pwm = 1'b0;
    rst_n = 1'b1;

    // R1 / R2 / R3: basic period
    step(1, 0, 1, 0, 0, 1, 0, "R1");
    hold(3, 1, 0, 1, 0, 0, 1, 0, "R1");
    step(0, 0, 1, 0, 0, 0, 0, "R2");
    hold(3, 0, 0, 1, 0, 0, 0, 0, "R2");
    step(0, 1, 1, 0, 0, 0, 1, "R2");
    hold(2, 0, 1, 1, 0, 0, 0, 1, "R2");
    step(1, 1, 1, 0, 0, 0, 0, "R3");
    hold(6, 1, 1, 1, 0, 0, 0, 0, "R3");
    step(1, 0, 1, 0, 0, 1, 0, "R3");

    // R4: switch node never falls
    step(0, 0, 1, 0, 0, 0, 0, "R4");
    hold(11, 0, 0, 1, 0, 0, 0, 0, "R4");
    step(0, 0, 1, 0, 0, 0, 1, "R4");
    hold(7, 1, 0, 1, 0, 0, 0, 0, "R3");
    step(1, 0, 1, 0, 0, 1, 0, "R3");

    // R9: single-cycle low request, no forced off time, no dead time
    step(0, 0, 1, 0, 0, 0, 0, "R9");
    step(1, 0, 1, 0, 0, 1, 0, "R9");
    hold(2, 1, 0, 1, 0, 0, 1, 0, "R9");

    // R5: bootstrap low ends high phase and forces refresh
    step(1, 0, 0, 0, 0, 0, 0, "R5");
    step(1, 1, 0, 0, 0, 0, 1, "R5");
    hold(4, 1, 1, 0, 0, 0, 0, 1, "R5");
    hold(20, 1, 1, 1, 0, 0, 0, 1, "R5");
    hold(7, 1, 1, 1, 0, 0, 0, 0, "R5");
    step(1, 1, 1, 0, 0, 1, 0, "R5");

    // R6: light load keeps low side off
    step(0, 0, 1, 1, 0, 0, 0, "R6");
    step(0, 1, 1, 1, 0, 0, 0, "R6");
    hold(3, 0, 1, 1, 1, 0, 0, 0, "R6");
    step(1, 1, 1, 1, 0, 1, 0, "R6");
    step(0, 1, 1, 0, 0, 0, 0, "R2");
    step(0, 1, 1, 0, 0, 0, 1, "R2");
    step(0, 1, 1, 1, 0, 0, 0, "R6");
    hold(6, 0, 1, 1, 1, 0, 0, 0, "R6");
    hold(3, 0, 1, 1, 1, 0, 0, 0, "R6");
    // R6: refresh overrides light load in the same cycle
    step(1, 1, 1, 1, 0, 1, 0, "R6");
    step(0, 1, 0, 1, 0, 0, 0, "R6");
    step(0, 1, 0, 1, 0, 0, 1, "R6");
    hold(24, 0, 1, 0, 1, 0, 0, 1, "R6");
    hold(7, 0, 1, 0, 1, 0, 0, 0, "R6");
    hold(3, 0, 1, 1, 1, 0, 0, 0, "R6");

    // R7: shutdown
    step(1, 1, 1, 0, 0, 1, 0, "R1");
    step(1, 1, 1, 0, 1, 0, 0, "R7");
    #1 check("R7", hs_en, ls_en, 1'b0, 1'b0);
    hold(3, 1, 1, 1, 0, 1, 0, 0, "R7");
    step(1, 1, 1, 0, 0, 1, 0, "R7");
    step(1, 1, 0, 0, 0, 0, 0, "R7");
    step(1, 1, 0, 0, 0, 0, 1, "R7");
    hold(3, 1, 1, 0, 0, 0, 0, 1, "R7");
    step(0, 1, 1, 0, 1, 0, 0, "R7");
    #1 check("R7", hs_en, ls_en, 1'b0, 1'b0);
    hold(4, 0, 1, 1, 0, 0, 0, 0, "R7");

    while (exp_q.size() != 0) @(posedge clk);
    @(posedge clk);
    #3;
    finish_run();
  end

endmodule